// File: doc/BRIEF.md
# Serial EEPROM Page Buffer and Write-Cycle Engine

This block sits behind the two-wire protocol controller of a small serial EEPROM model. During a write transaction the controller first hands over the word address, then one strobe per received data byte. The block keeps these bytes in an eight-byte page buffer. Each byte goes into the lane picked by the low three bits of an internal address counter. After each byte only those three bits advance, so the counter wraps inside the page and never crosses into the next one. A ninth or later byte therefore overwrites an earlier lane.

When the controller reports a STOP and at least one byte has been collected, the block starts a self-timed write cycle. Its length is a parameter counted in system clocks. The busy flag stays high for the whole cycle, and the controller uses it to refuse the bus. At the end of the cycle, only the lanes written in this transaction are copied into the 256-byte storage array. The write-control level captured at the STOP can suppress that copy. The array has a registered read port that works whatever the write-control level.

Top module: `eep_page_engine`

## Requirements
- R1: After reset the busy flag is low, the address counter is 0x00 and every array byte reads 0xFF.
- R2: A data byte accepted after a word address is loaded appears in the array at that address once the write cycle following STOP has ended.
- R3: Each accepted byte advances only address bits [2:0], modulo 8, and bits [7:3] stay fixed. The address counter ends one past the last byte written, wrapped within the page.
- R4: When more than 8 bytes arrive in one transaction, the later bytes overwrite the earlier ones in their lanes. The last value written to each lane is the one committed.
- R5: Only the lanes written in the current transaction are committed. All other bytes of the page keep their previous contents.
- R6: The array does not change before STOP. A STOP with collected data raises the busy flag on the next clock, and it stays high for exactly WR_CYCLES clocks.
- R7: While busy, address loads, byte strobes and STOP strobes have no effect. They do not change the address counter or the data that is committed, and they do not start another cycle.
- R8: If write-control is high when STOP is accepted, the write cycle still runs but no array byte changes.
- R9: A STOP with no data byte collected, for example after an address-only transaction, starts no write cycle, and busy stays low.
- R10: The read port returns the byte at the requested address one clock later, with write-control either high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld_i | input | 1 | Strobe: load word address, open a new transaction |
| addr_i | input | 8 | Word address loaded by addr_ld_i |
| byte_wr_i | input | 1 | Strobe: one received data byte |
| wr_data_i | input | 8 | Data byte for byte_wr_i |
| stop_i | input | 1 | Strobe: STOP ended the transaction |
| wp_i | input | 1 | Write-control level, high blocks the commit |
| busy_o | output | 1 | Write cycle in progress |
| cur_addr_o | output | 8 | Internal address counter |
| rd_addr_i | input | 8 | Read port address |
| rd_data_o | output | 8 | Read port data, one clock after rd_addr_i |

## Verification
The bench builds the block with WR_CYCLES set to 6 instead of the 10 ms default. This lets it count each busy period exactly, and it can send address, byte and STOP strobes inside one cycle to show that they are dropped. The default depth of 256 and page size of 8 are kept. This puts the ten-byte overflow, the wrap from lane 7 to lane 0 and the page boundary next to untouched neighbours within reach of a few short transactions.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/eep_cycle_timer.sv
module eep_cycle_timer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WR_CYCLES) + 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        done_o = s_q.busy && (s_q.cnt == '0);
        if (s_q.busy) begin
            if (done_o) s_d.busy = 1'b0;
            else        s_d.cnt  = s_q.cnt - 1'b1;
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CW'(WR_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && (s_q.cnt != '0) |=> s_q.busy);
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !s_q.busy |=> s_q.busy);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PAGE  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_ld_i,
    input  logic [$clog2(DEPTH)-1:0]  addr_i,
    input  logic                      byte_wr_i,
    input  byte_t                     wr_data_i,
    input  logic                      stop_i,
    input  logic                      wp_i,
    input  logic                      busy_i,
    input  logic                      done_i,
    output logic                      start_o,
    output logic                      prot_o,
    output logic [$clog2(DEPTH)-1:0]  addr_o,
    output logic [PAGE-1:0]           mask_o,
    output byte_t [PAGE-1:0]          lanes_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(PAGE);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [PAGE-1:0]  mask;
        byte_t [PAGE-1:0] data;
        logic             prot;
    } pbuf_t;

    pbuf_t s_d, s_q;
    logic [LW-1:0] lane;

    assign lane = s_q.addr[LW-1:0];

    always_comb begin
        s_d     = s_q;
        start_o = stop_i && !busy_i && (|s_q.mask);
        if (!busy_i) begin
            if (addr_ld_i) begin
                s_d.addr = addr_i;
                s_d.mask = '0;
            end else if (byte_wr_i) begin
                s_d.data[lane]        = wr_data_i;
                s_d.mask[lane]        = 1'b1;
                s_d.addr[LW-1:0]      = lane + 1'b1;
            end
            if (start_o) s_d.prot = wp_i;
        end
        if (done_i) s_d.mask = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prot_o  = s_q.prot;
    assign addr_o  = s_q.addr;
    assign mask_o  = s_q.mask;
    assign lanes_o = s_q.data;

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr_i && !busy_i && !addr_ld_i |=> s_q.addr[AW-1:LW] == $past(s_q.addr[AW-1:LW]));
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !done_i |=> $stable(s_q.data) && $stable(s_q.addr) && $stable(s_q.prot));
endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PAGE  = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    we_i,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0]   row_i,
    input  logic [PAGE-1:0]                         mask_i,
    input  byte_t [PAGE-1:0]                        lanes_i,
    input  logic [$clog2(DEPTH)-1:0]                rd_addr_i,
    output byte_t                                   rd_data_o
);
    localparam int LW   = $clog2(PAGE);
    localparam int ROWS = DEPTH / PAGE;

    typedef struct packed {
        byte_t [ROWS-1:0][PAGE-1:0] mem;
        byte_t                      rd;
    } arr_t;

    arr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.rd = s_q.mem[rd_addr_i[$clog2(DEPTH)-1:LW]][rd_addr_i[LW-1:0]];
        for (int l = 0; l < PAGE; l++) begin
            if (we_i && mask_i[l]) s_d.mem[row_i][l] = lanes_i[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.rd;

    p_hold_no_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(s_q.mem));
endmodule

// File: rtl/eep_page_engine.sv
module eep_page_engine
    import eep_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int PAGE      = 8,
    parameter int WR_CYCLES = 500000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      addr_ld_i,
    input  logic [$clog2(DEPTH)-1:0]  addr_i,
    input  logic                      byte_wr_i,
    input  logic [7:0]                wr_data_i,
    input  logic                      stop_i,
    input  logic                      wp_i,
    output logic                      busy_o,
    output logic [$clog2(DEPTH)-1:0]  cur_addr_o,
    input  logic [$clog2(DEPTH)-1:0]  rd_addr_i,
    output logic [7:0]                rd_data_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(PAGE);

    logic             start, done, prot;
    logic [PAGE-1:0]  mask;
    byte_t [PAGE-1:0] lanes;

    eep_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_o), .done_o(done)
    );

    eep_page_buf #(.DEPTH(DEPTH), .PAGE(PAGE)) u_buf (
        .clk(clk), .rst_n(rst_n), .addr_ld_i(addr_ld_i), .addr_i(addr_i),
        .byte_wr_i(byte_wr_i), .wr_data_i(wr_data_i), .stop_i(stop_i), .wp_i(wp_i),
        .busy_i(busy_o), .done_i(done), .start_o(start), .prot_o(prot),
        .addr_o(cur_addr_o), .mask_o(mask), .lanes_o(lanes)
    );

    eep_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_arr (
        .clk(clk), .rst_n(rst_n), .we_i(done && !prot), .row_i(cur_addr_o[AW-1:LW]),
        .mask_i(mask), .lanes_i(lanes), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    p_idle_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !busy_o && !start |=> !busy_o);
endmodule

// File: tb/sim_eep_page_engine.sv
module sim_eep_page_engine;
    localparam int W = 6;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       addr_ld = 0, byte_wr = 0, stop = 0, wp = 0;
    logic [7:0] addr = 0, wdata = 0, rd_addr = 0;
    logic       busy;
    logic [7:0] cur_addr, rd_data;

    int errors = 0, checks = 0, cyc = 0;
    int    exp_q[$];
    int    due_q[$];
    int    ad_q[$];
    string tag_q[$];

    eep_page_engine #(.DEPTH(256), .PAGE(8), .WR_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_ld_i(addr_ld), .addr_i(addr),
        .byte_wr_i(byte_wr), .wr_data_i(wdata), .stop_i(stop), .wp_i(wp),
        .busy_o(busy), .cur_addr_o(cur_addr), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: compares read data once its latency has elapsed
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            void'(due_q.pop_front());
            chk(int'(rd_data), exp_q.pop_front(),
                $sformatf("%s rd[%0h]", tag_q.pop_front(), ad_q.pop_front()));
        end
    end

    task automatic tick(); @(negedge clk); endtask
    task automatic load(input int a); addr_ld = 1; addr = 8'(a); tick(); addr_ld = 0; endtask
    task automatic put(input int d); byte_wr = 1; wdata = 8'(d); tick(); byte_wr = 0; endtask
    task automatic stp(); stop = 1; tick(); stop = 0; endtask
    task automatic rd(input int a, input int e, input string tag);
        rd_addr = 8'(a);
        exp_q.push_back(e); due_q.push_back(cyc + 1); ad_q.push_back(a); tag_q.push_back(tag);
        tick();
    endtask
    task automatic drain(); tick(); tick(); endtask
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 100) begin n++; tick(); end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(busy, 0, "R1 busy");
        chk(cur_addr, 0, "R1 addr");
        rd(8'h00, 8'hFF, "R1"); rd(8'hFF, 8'hFF, "R1"); drain();

        // R2/R6 single byte
        load(8'h15); put(8'hA5);
        rd(8'h15, 8'hFF, "R6 before stop"); drain();
        stp();
        busy_len(n);
        chk(n, W, "R6 busy length");
        rd(8'h15, 8'hA5, "R2"); rd(8'h14, 8'hFF, "R5"); rd(8'h16, 8'hFF, "R5"); drain();
        chk(cur_addr, 8'h16, "R3 addr after byte");

        // R3/R4 ten bytes from lane 6 of page 0x18
        load(8'h1E);
        for (int i = 0; i < 10; i++) put(8'h30 + i);
        chk(cur_addr, 8'h18, "R3 wrapped addr");
        stp(); busy_len(n);
        rd(8'h1E, 8'h38, "R4"); rd(8'h1F, 8'h39, "R4");
        for (int i = 0; i < 6; i++) rd(8'h18 + i, 8'h32 + i, "R4");
        rd(8'h20, 8'hFF, "R3 next page"); rd(8'h17, 8'hFF, "R3 prev page"); drain();

        // R5 partial rewrite of full page
        load(8'h40);
        for (int i = 0; i < 8; i++) put(8'h50 + i);
        stp(); busy_len(n);
        load(8'h43); put(8'h77); stp(); busy_len(n);
        for (int i = 0; i < 8; i++) rd(8'h40 + i, (i == 3) ? 8'h77 : 8'h50 + i, "R5");
        drain();

        // R7 strobes during busy are dropped
        load(8'h60); put(8'h12); stp();
        load(8'h70); put(8'h99); stp();
        busy_len(n);
        chk(n + 3, W, "R7 busy not extended");
        tick();
        chk(busy, 0, "R7 no second cycle");
        chk(cur_addr, 8'h61, "R7 addr untouched");
        rd(8'h60, 8'h12, "R7"); rd(8'h70, 8'hFF, "R7"); rd(8'h61, 8'hFF, "R7"); drain();

        // R8 protected commit, R10 reads with wp high
        wp = 1;
        load(8'h15); put(8'h3C); stp();
        busy_len(n);
        chk(n, W, "R8 cycle runs");
        rd(8'h15, 8'hA5, "R8 R10"); rd(8'h40, 8'h50, "R10"); drain();
        wp = 0;

        // R9 address-only transaction
        load(8'h80); stp();
        chk(busy, 0, "R9 busy");
        tick();
        chk(busy, 0, "R9 busy later");
        chk(cur_addr, 8'h80, "R9 addr");
        rd(8'h80, 8'hFF, "R9"); drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule